// File: doc/BRIEF.md
# Masked Bus Data Match Comparator

This block watches a 16-bit data bus and raises a one-cycle match flag when a qualified bus access carries a value that agrees with a programmable pattern on every bit that a per-bit mask selects. Bits whose mask bit is clear do not take part in the comparison. A tag-mode control bit turns the data comparison off entirely, so no match can come from it while that bit is set.

Software programs the pattern and the mask a byte at a time through a byte-wide register port. The four byte registers occupy four consecutive offsets starting at 0x2D. They are reachable only while the bank-select input is 2'b00. Writes are also refused while the surrounding debug unit reports that it is armed, which keeps the comparison setup fixed during a capture.

The bus side is a pure monitor. It accepts every strobed access in the cycle it is presented, so there is no ready signal and no back-pressure: `bus_valid` qualifies `bus_data` for exactly one cycle, and the result shows up on `match` one clock later.

Top module: `bus_data_match`

## Requirements
- R1: Pattern high byte bits [7:0] are compared with bus bits [15:8], and pattern low byte bits [7:0] are compared with bus bits [7:0]. A pattern bit of 0 needs a 0 on the bus and a pattern bit of 1 needs a 1.
- R2: A mask bit of 0 makes its bus bit a don't-care. With an all-zero mask, every valid access gives a match while tag mode is clear.
- R3: `match` is registered. It is 1 in the cycle after a cycle with `bus_valid`=1, tag mode clear, and masked bus data equal to the masked pattern. In every other case it is 0 in that following cycle.
- R4: While `tag_mode`=1 the data comparison is disabled and `match` is 0 in the following cycle, whatever the bus carries.
- R5: With `bank_sel`=2'b00, `reg_rdata` returns the register at `reg_addr` combinationally. With any other `bank_sel`, or an address outside the four offsets, it returns 0.
- R6: A write with `reg_wr`=1 changes the addressed register at the clock edge only when `bank_sel`=2'b00 and `armed`=0. Every other write leaves all four registers unchanged.
- R7: After reset all pattern and mask bits are 0 and `match` is 0.
- R8: The register offsets are 0x2D for the pattern high byte, 0x2E for the pattern low byte, 0x2F for the mask high byte and 0x30 for the mask low byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 8 | Register offset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational |
| bank_sel | input | 2 | Register window select; 2'b00 opens the data-match registers |
| armed | input | 1 | Debug unit armed; blocks writes |
| tag_mode | input | 1 | 1 disables the data comparison |
| bus_valid | input | 1 | Qualifies bus_data for one cycle |
| bus_data | input | 16 | Monitored bus value |
| match | output | 1 | Registered match result |

## Verification
The assertions take all inputs to be synchronous to `clk` and stable around the rising edge. They also treat `tag_mode` and `bus_valid` as sampled in the same cycle as `bus_data`, so a result always depends on one cycle's inputs only. The bench changes every input at the falling edge and samples the outputs at the next falling edge, so that assumption holds throughout. The stimulus covers every single-bit mask position, a sweep over randomly chosen pattern, mask and data values, and writes deliberately attempted while armed or with a nonzero bank.

// File: rtl/dm_pkg.sv
package dm_pkg;
  localparam logic [1:0] BANK_DATA = 2'b00;  // window holding pattern and mask
  localparam int unsigned BYTE_W = 8;
endpackage

// File: rtl/dm_regs.sv
module dm_regs
  import dm_pkg::*;
#(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 16,
  parameter logic [AW-1:0] BASE = 8'h2D
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     addr,
  input  logic              wr,
  input  logic [BYTE_W-1:0] wdata,
  input  logic [1:0]        bank_sel,
  input  logic              armed,
  output logic [BYTE_W-1:0] rdata,
  output logic [DW-1:0]     pattern,
  output logic [DW-1:0]     mask
);
  localparam int unsigned NB   = DW / BYTE_W;
  localparam int unsigned NREG = 2 * NB;
  localparam int unsigned IW   = (NREG > 1) ? $clog2(NREG) : 1;

  logic [BYTE_W-1:0] regq [NREG];
  logic [AW-1:0]     off;
  logic              hit;
  logic              open_win;
  logic              wr_en;

  assign off      = addr - BASE;
  assign hit      = (addr >= BASE) && (off < AW'(NREG));
  assign open_win = (bank_sel == BANK_DATA);
  assign wr_en    = wr && open_win && !armed && hit;

  // index 0..NB-1: pattern bytes, most significant first; then mask bytes
  for (genvar k = 0; k < NREG; k++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          regq[k] <= '0;
      else if (wr_en && off == AW'(k))     regq[k] <= wdata;
    end
  end

  for (genvar b = 0; b < NB; b++) begin : g_map
    assign pattern[BYTE_W*b +: BYTE_W] = regq[NB-1-b];
    assign mask[BYTE_W*b +: BYTE_W]    = regq[2*NB-1-b];
  end

  always_comb begin
    rdata = '0;
    if (open_win && hit) rdata = regq[off[IW-1:0]];
  end

  // R6: refused writes leave the whole register set unchanged
  assert_wr_blocked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && (armed || bank_sel != BANK_DATA)) |=> $stable({pattern, mask}));

  // R6: no write strobe, no register change
  assert_no_spurious_wr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable({pattern, mask}));

  // R5: a closed window reads as zero
  assert_closed_read_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_sel != BANK_DATA) |-> (rdata == '0));
endmodule

// File: rtl/dm_compare.sv
module dm_compare #(
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          valid,
  input  logic          tag_mode,
  input  logic [DW-1:0] data,
  input  logic [DW-1:0] pattern,
  input  logic [DW-1:0] mask,
  output logic          match
);
  logic [DW-1:0] diff;
  logic          agree;

  assign diff  = (data ^ pattern) & mask;
  assign agree = ~|diff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) match <= 1'b0;
    else        match <= valid && !tag_mode && agree;
  end

  // R4: tag mode suppresses the data match
  assert_tag_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tag_mode |=> !match);

  // R3: no strobe, no match
  assert_idle_no_match_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |=> !match);

  // R2: an empty mask matches every qualified access
  assert_empty_mask_hits_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !tag_mode && mask == '0) |=> match);

  // R1: exact full-mask equality gives a match
  assert_exact_hits_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !tag_mode && data == pattern) |=> match);
endmodule

// File: rtl/bus_data_match.sv
module bus_data_match
  import dm_pkg::*;
#(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 16,
  parameter logic [AW-1:0] BASE = 8'h2D
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     reg_addr,
  input  logic              reg_wr,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] reg_rdata,
  input  logic [1:0]        bank_sel,
  input  logic              armed,
  input  logic              tag_mode,
  input  logic              bus_valid,
  input  logic [DW-1:0]     bus_data,
  output logic              match
);
  logic [DW-1:0] pattern;
  logic [DW-1:0] mask;

  dm_regs #(.AW(AW), .DW(DW), .BASE(BASE)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(reg_addr), .wr(reg_wr), .wdata(reg_wdata),
    .bank_sel(bank_sel), .armed(armed), .rdata(reg_rdata),
    .pattern(pattern), .mask(mask)
  );

  dm_compare #(.DW(DW)) u_cmp (
    .clk(clk), .rst_n(rst_n), .valid(bus_valid), .tag_mode(tag_mode),
    .data(bus_data), .pattern(pattern), .mask(mask), .match(match)
  );

  // R7: match is low in the first cycle after reset release
  assert_reset_quiet_R7: assert property (@(posedge clk)
    $rose(rst_n) |-> !match);
endmodule

// File: tb/tb_bus_data_match.sv
module tb_bus_data_match;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [7:0]  reg_addr = 0;
  logic        reg_wr = 0;
  logic [7:0]  reg_wdata = 0;
  logic [7:0]  reg_rdata;
  logic [1:0]  bank_sel = 0;
  logic        armed = 0;
  logic        tag_mode = 0;
  logic        bus_valid = 0;
  logic [15:0] bus_data = 0;
  logic        match;

  int checks = 0;
  int errors = 0;

  localparam logic [7:0] A_PH = 8'h2D, A_PL = 8'h2E, A_MH = 8'h2F, A_ML = 8'h30;

  always #2 clk = ~clk;  // 250 MHz

  bus_data_match dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bank_sel(bank_sel),
    .armed(armed), .tag_mode(tag_mode), .bus_valid(bus_valid),
    .bus_data(bus_data), .match(match)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(input string req, input logic [7:0] a, input logic [7:0] exp);
    @(negedge clk);
    reg_addr = a;
    #1;
    chk(req, reg_rdata, exp);
  endtask

  task automatic prog(input logic [15:0] p, input logic [15:0] m);
    bank_sel = 2'b00; armed = 0;
    wr(A_PH, p[15:8]); wr(A_PL, p[7:0]); wr(A_MH, m[15:8]); wr(A_ML, m[7:0]);
  endtask

  // drive one bus cycle, return the match seen one clock later
  task automatic bus(input logic v, input logic t, input logic [15:0] d, output logic m);
    @(negedge clk);
    bus_valid = v; tag_mode = t; bus_data = d;
    @(negedge clk);
    bus_valid = 0; tag_mode = 0;
    m = match;
  endtask

  initial begin
    #400000;
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic m;
    logic [15:0] p, msk, d;
    logic v, t;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R7 reset state
    chk("R7 match", match, 0);
    rd("R7 ph", A_PH, 0); rd("R7 pl", A_PL, 0);
    rd("R7 mh", A_MH, 0); rd("R7 ml", A_ML, 0);

    // R2: empty mask after reset matches anything
    bus(1, 0, 16'hBEEF, m); chk("R2 empty mask", m, 1);
    bus(0, 0, 16'hBEEF, m); chk("R3 no valid", m, 0);

    // R8 / R5 offsets and readback
    prog(16'hA55A, 16'h3CC3);
    rd("R8 ph", A_PH, 8'hA5); rd("R8 pl", A_PL, 8'h5A);
    rd("R8 mh", A_MH, 8'h3C); rd("R8 ml", A_ML, 8'hC3);
    rd("R5 below", 8'h2C, 0); rd("R5 above", 8'h31, 0);
    bank_sel = 2'b10;
    rd("R5 bank2", A_PH, 0);
    bank_sel = 2'b01;
    rd("R5 bank1", A_ML, 0);
    bank_sel = 2'b00;

    // R6: blocked while armed
    armed = 1;
    wr(A_PH, 8'h11); wr(A_ML, 8'h22);
    armed = 0;
    rd("R6 armed ph", A_PH, 8'hA5); rd("R6 armed ml", A_ML, 8'hC3);
    // R6: blocked with nonzero bank
    for (int b = 1; b < 4; b++) begin
      bank_sel = 2'(b);
      wr(A_PL, 8'h77); wr(A_MH, 8'h88);
    end
    bank_sel = 2'b00;
    rd("R6 bank pl", A_PL, 8'h5A); rd("R6 bank mh", A_MH, 8'h3C);

    // R1: full mask, byte placement
    prog(16'h12F0, 16'hFFFF);
    bus(1, 0, 16'h12F0, m); chk("R1 exact", m, 1);
    bus(1, 0, 16'hF012, m); chk("R1 swapped bytes", m, 0);
    bus(1, 1, 16'h12F0, m); chk("R4 tag blocks", m, 0);

    // R1/R2: every single-bit mask position
    for (int i = 0; i < 16; i++) begin
      p = 16'h6B39 ^ 16'(i * 16'h1357);
      prog(p, 16'(1) << i);
      bus(1, 0, ~p ^ (16'(1) << i), m); chk("R2 only bit set agrees", m, 1);
      bus(1, 0, p ^ (16'(1) << i), m);  chk("R1 masked bit differs", m, 0);
    end

    // R2/R3/R4 random sweep against an arithmetic model
    for (int n = 0; n < 300; n++) begin
      p = 16'($urandom); msk = 16'($urandom);
      if (n % 5 == 0) msk = 0;
      prog(p, msk);
      d = (n % 2 == 0) ? (p ^ (16'($urandom) & ~msk)) : 16'($urandom);
      v = ($urandom % 4) != 0;
      t = ($urandom % 5) == 0;
      bus(v, t, d, m);
      chk("R3 random model", m, int'(v && !t && (((d ^ p) & msk) == 0)));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule